// File: doc/BRIEF.md
# Four-Beat Double-Rate Memory Read Port

This block is the read side of a synchronous memory with separate read and write ports. Each address selects one location of four 18-bit words. A read request is sampled on a rising clock edge. The block then returns the four words of that location, two per clock cycle. Each cycle carries a first-half lane and a second-half lane, so together they model data moving on both clock phases. The words come out lowest first, and the burst lasts two cycles.

The block also holds the write path, because it needs it in order to return fresh data. A write location is requested on one edge, and its four words arrive over the next two edges. The location is committed to the array on the second of those edges. A read that is accepted on the edge right after a write to the same location returns the new data, merged byte by byte, even though the array has not been updated yet. While no burst is in flight, the output-enable signal is low and both lanes read zero. This stands in for a high-impedance data bus.

Top module: `burst4_rd_port`

## Requirements
- R1: After reset, `rd_oe`, `rd_vld_lo` and `rd_vld_hi` are low and both data lanes read zero.
- R2: A read of location A returns array words 4A+0 and 4A+1 on the low and high lanes in its first output cycle. It returns 4A+2 and 4A+3 on the low and high lanes in its second output cycle.
- R3: For a read accepted at edge t, the lanes are still not valid after edge t. Words 0/1 are valid after edge t+1, and words 2/3 are valid after edge t+2.
- R4: A read request at the edge directly after an accepted read is ignored and produces no burst.
- R5: When reads are requested on every other edge, `rd_oe` and both valid flags stay high without a gap, and each burst carries its own location's data.
- R6: Once a burst has finished and no new read was accepted, `rd_oe` is low after the following edge (t+3 for a read at t). A burst in flight still completes after `rd_sel_n` returns high.
- R7: Forwarding: a read accepted on the edge after a write to the same location was accepted returns the post-write value of all four words. Only the bytes that the write enabled are new; the other bytes come from the array.
- R8: Write protocol: the write request and `wr_addr` are sampled at edge t. Words 0/1 are sampled on `wr_d_lo`/`wr_d_hi` at edge t+1, and words 2/3 at edge t+2. Byte lane 0 is bits 8:0 and lane 1 is bits 17:9. The byte selects are active low, and a deselected byte keeps its old value.
- R9: A read accepted on the same edge as a write to the same location returns the contents from before that write, for all four words.
- R10: A write request at the edge directly after an accepted write is ignored. It changes no location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| rd_sel_n | input | 1 | Read request, active low |
| rd_addr | input | LOC_AW | Read location |
| wr_sel_n | input | 1 | Write request, active low |
| wr_addr | input | LOC_AW | Write location |
| wr_d_lo | input | 18 | Write word for the first half of a data cycle |
| wr_d_hi | input | 18 | Write word for the second half of a data cycle |
| wr_bsel_n_lo | input | 2 | Byte selects for `wr_d_lo`, active low |
| wr_bsel_n_hi | input | 2 | Byte selects for `wr_d_hi`, active low |
| rd_q_lo | output | 18 | Read word, first half-cycle lane |
| rd_q_hi | output | 18 | Read word, second half-cycle lane |
| rd_vld_lo | output | 1 | Low lane carries a valid word |
| rd_vld_hi | output | 1 | High lane carries a valid word |
| rd_oe | output | 1 | Output drive enable; low means the bus is released |

## Verification
The bench builds the block with `LOC_AW = 3`, which gives eight locations and thirty-two words. This size lets every location be filled, read back one at a time and then streamed back-to-back. It also lets each location take one forwarding case and one partial byte-select pattern, so all four mask values appear on every beat position. The small array also keeps the expected contents cheap to model as a plain array in the bench. With that model, the same-edge, next-edge and ignored-request orderings are each checked against exact word values.

// File: rtl/b4rd_pkg.sv
package b4rd_pkg;

    localparam int BYTE_W = 9;
    localparam int LANES  = 2;
    localparam int WORD_W = BYTE_W * LANES;
    localparam int BEATS  = 4;
    localparam int PAIR   = 2;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [LANES-1:0]  bmask_t;

    // One write beat: data with active-high byte enables
    typedef struct packed {
        word_t  data;
        bmask_t en;
    } beat_t;

    typedef enum logic [1:0] {
        RD_IDLE  = 2'd0,
        RD_PAIR0 = 2'd1,
        RD_PAIR1 = 2'd2
    } rd_phase_e;

    typedef enum logic [1:0] {
        WR_IDLE  = 2'd0,
        WR_PAIR0 = 2'd1,
        WR_PAIR1 = 2'd2
    } wr_phase_e;

    // Replace only the enabled byte lanes of base with those of upd
    function automatic word_t lane_merge(word_t base, word_t upd, bmask_t en);
        word_t r;
        r = base;
        for (int i = 0; i < LANES; i++) begin
            if (en[i]) r[i*BYTE_W +: BYTE_W] = upd[i*BYTE_W +: BYTE_W];
        end
        return r;
    endfunction

endpackage

// File: rtl/b4rd_rd_ctrl.sv
module b4rd_rd_ctrl
    import b4rd_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_sel_n,
    input  logic [AW-1:0] rd_addr,
    output logic          accept,
    output rd_phase_e     phase,
    output logic [AW-1:0] addr_q
);

    // A request is dropped on the edge right after an accepted one
    assign accept = !rd_sel_n && (phase != RD_PAIR0);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= RD_IDLE;
            addr_q <= '0;
        end else if (accept) begin
            phase  <= RD_PAIR0;
            addr_q <= rd_addr;
        end else if (phase == RD_PAIR0) begin
            phase  <= RD_PAIR1;
        end else begin
            phase  <= RD_IDLE;
        end
    end

    AST_RD_SPACING: assert property (@(posedge clk) disable iff (rst)
        accept |=> !accept); // R4

endmodule

// File: rtl/b4rd_wr_stage.sv
module b4rd_wr_stage
    import b4rd_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_sel_n,
    input  logic [AW-1:0]        wr_addr,
    input  word_t                d_lo,
    input  word_t                d_hi,
    input  bmask_t               en_lo,
    input  bmask_t               en_hi,
    output logic                 commit,
    output logic [AW-1:0]        waddr_q,
    output beat_t [BEATS-1:0]    commit_beats,
    output logic                 fwd_valid,
    output beat_t [PAIR-1:0]     fwd_beats
);

    wr_phase_e        phase;
    beat_t [PAIR-1:0] held;
    logic             accept;

    assign accept = !wr_sel_n && (phase != WR_PAIR0);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= WR_IDLE;
            waddr_q <= '0;
            held    <= '0;
        end else begin
            if (accept) begin
                phase   <= WR_PAIR0;
                waddr_q <= wr_addr;
            end else if (phase == WR_PAIR0) begin
                phase   <= WR_PAIR1;
            end else begin
                phase   <= WR_IDLE;
            end
            if (phase == WR_PAIR0) begin
                held[0] <= {d_lo, en_lo};
                held[1] <= {d_hi, en_hi};
            end
        end
    end

    // Second data cycle: the whole location is committed at this edge
    assign commit          = (phase == WR_PAIR1);
    assign commit_beats[0] = held[0];
    assign commit_beats[1] = held[1];
    assign commit_beats[2] = {d_lo, en_lo};
    assign commit_beats[3] = {d_hi, en_hi};

    // Words 0/1 sit in held until that commit edge
    assign fwd_valid = commit;
    assign fwd_beats = held;

    AST_WR_SPACING: assert property (@(posedge clk) disable iff (rst)
        accept |=> !accept); // R10

endmodule

// File: rtl/b4rd_array.sv
module b4rd_array
    import b4rd_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic                 clk,
    input  logic                 we,
    input  logic [AW-1:0]        waddr,
    input  beat_t [BEATS-1:0]    wbeats,
    input  logic [AW-1:0]        raddr,
    input  logic                 rsel_hi,
    output word_t [PAIR-1:0]     rwords
);

    localparam int LOCS  = 1 << AW;
    localparam int WORDS = LOCS * BEATS;
    localparam int BW    = $clog2(BEATS);
    localparam int PW    = $clog2(PAIR);

    word_t mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            for (int b = 0; b < BEATS; b++) begin
                for (int l = 0; l < LANES; l++) begin
                    if (wbeats[b].en[l]) begin
                        mem[{waddr, BW'(b)}][l*BYTE_W +: BYTE_W] <=
                            wbeats[b].data[l*BYTE_W +: BYTE_W];
                    end
                end
            end
        end
    end

    for (genvar p = 0; p < PAIR; p++) begin : g_rd
        assign rwords[p] = mem[{raddr, rsel_hi, PW'(p)}];
    end

endmodule

// File: rtl/b4rd_out_stage.sv
module b4rd_out_stage
    import b4rd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             hit,
    input  word_t [PAIR-1:0] arr_words,
    input  beat_t [PAIR-1:0] fwd_beats,
    output word_t            q_lo,
    output word_t            q_hi,
    output logic             vld_lo,
    output logic             vld_hi,
    output logic             oe
);

    word_t [PAIR-1:0] merged;

    for (genvar p = 0; p < PAIR; p++) begin : g_fwd
        assign merged[p] = hit ? lane_merge(arr_words[p], fwd_beats[p].data, fwd_beats[p].en)
                               : arr_words[p];
    end

    always_ff @(posedge clk) begin
        if (rst || !load) begin
            q_lo   <= '0;
            q_hi   <= '0;
            vld_lo <= 1'b0;
            vld_hi <= 1'b0;
            oe     <= 1'b0;
        end else begin
            q_lo   <= merged[0];
            q_hi   <= merged[1];
            vld_lo <= 1'b1;
            vld_hi <= 1'b1;
            oe     <= 1'b1;
        end
    end

    AST_OE_FROM_LOAD: assert property (@(posedge clk) disable iff (rst)
        $rose(oe) |-> $past(load)); // R3

endmodule

// File: rtl/burst4_rd_port.sv
module burst4_rd_port
    import b4rd_pkg::*;
#(
    parameter int LOC_AW = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_sel_n,
    input  logic [LOC_AW-1:0] rd_addr,
    input  logic              wr_sel_n,
    input  logic [LOC_AW-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_d_lo,
    input  logic [WORD_W-1:0] wr_d_hi,
    input  logic [LANES-1:0]  wr_bsel_n_lo,
    input  logic [LANES-1:0]  wr_bsel_n_hi,
    output logic [WORD_W-1:0] rd_q_lo,
    output logic [WORD_W-1:0] rd_q_hi,
    output logic              rd_vld_lo,
    output logic              rd_vld_hi,
    output logic              rd_oe
);

    logic               rd_accept;
    rd_phase_e          rd_phase;
    logic [LOC_AW-1:0]  rd_addr_q;
    logic               commit;
    logic [LOC_AW-1:0]  waddr_q;
    beat_t [BEATS-1:0]  commit_beats;
    logic               fwd_valid;
    beat_t [PAIR-1:0]   fwd_beats;
    word_t [PAIR-1:0]   arr_words;
    logic               fwd_hit;

    b4rd_rd_ctrl #(.AW(LOC_AW)) u_rd_ctrl (
        .clk      (clk),
        .rst      (rst),
        .rd_sel_n (rd_sel_n),
        .rd_addr  (rd_addr),
        .accept   (rd_accept),
        .phase    (rd_phase),
        .addr_q   (rd_addr_q)
    );

    b4rd_wr_stage #(.AW(LOC_AW)) u_wr_stage (
        .clk          (clk),
        .rst          (rst),
        .wr_sel_n     (wr_sel_n),
        .wr_addr      (wr_addr),
        .d_lo         (wr_d_lo),
        .d_hi         (wr_d_hi),
        .en_lo        (~wr_bsel_n_lo),
        .en_hi        (~wr_bsel_n_hi),
        .commit       (commit),
        .waddr_q      (waddr_q),
        .commit_beats (commit_beats),
        .fwd_valid    (fwd_valid),
        .fwd_beats    (fwd_beats)
    );

    b4rd_array #(.AW(LOC_AW)) u_array (
        .clk     (clk),
        .we      (commit),
        .waddr   (waddr_q),
        .wbeats  (commit_beats),
        .raddr   (rd_addr_q),
        .rsel_hi (rd_phase == RD_PAIR1),
        .rwords  (arr_words)
    );

    // Words 0/1 of a write accepted one edge before this read are still held
    assign fwd_hit = fwd_valid && (rd_phase == RD_PAIR0) && (waddr_q == rd_addr_q);

    b4rd_out_stage u_out (
        .clk       (clk),
        .rst       (rst),
        .load      (rd_phase != RD_IDLE),
        .hit       (fwd_hit),
        .arr_words (arr_words),
        .fwd_beats (fwd_beats),
        .q_lo      (rd_q_lo),
        .q_hi      (rd_q_hi),
        .vld_lo    (rd_vld_lo),
        .vld_hi    (rd_vld_hi),
        .oe        (rd_oe)
    );

    AST_BURST_LATENCY: assert property (@(posedge clk) disable iff (rst)
        rd_accept |-> ##2 rd_oe ##1 rd_oe); // R3

    AST_OE_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (!rd_accept && !$past(rd_accept)) |-> ##2 !rd_oe); // R6

endmodule

// File: tb/burst4_rd_port_tb.sv
`timescale 1ns/1ps
module burst4_rd_port_tb;

    localparam int AW   = 3;
    localparam int LOCS = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rd_sel_n = 1'b1;
    logic [AW-1:0] rd_addr = '0;
    logic          wr_sel_n = 1'b1;
    logic [AW-1:0] wr_addr = '0;
    logic [17:0]   wr_d_lo = '0;
    logic [17:0]   wr_d_hi = '0;
    logic [1:0]    wr_bsel_n_lo = 2'b11;
    logic [1:0]    wr_bsel_n_hi = 2'b11;
    logic [17:0]   rd_q_lo;
    logic [17:0]   rd_q_hi;
    logic          rd_vld_lo;
    logic          rd_vld_hi;
    logic          rd_oe;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    logic [17:0] mdl [LOCS*4];

    always #2 clk = ~clk;

    burst4_rd_port #(.LOC_AW(AW)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .rd_sel_n     (rd_sel_n),
        .rd_addr      (rd_addr),
        .wr_sel_n     (wr_sel_n),
        .wr_addr      (wr_addr),
        .wr_d_lo      (wr_d_lo),
        .wr_d_hi      (wr_d_hi),
        .wr_bsel_n_lo (wr_bsel_n_lo),
        .wr_bsel_n_hi (wr_bsel_n_hi),
        .rd_q_lo      (rd_q_lo),
        .rd_q_hi      (rd_q_hi),
        .rd_vld_lo    (rd_vld_lo),
        .rd_vld_hi    (rd_vld_hi),
        .rd_oe        (rd_oe)
    );

    function automatic logic [17:0] pat(int gen, int loc, int w);
        return 18'((gen * 40503 + (loc * 4 + w) * 2749 + 77) % 262144);
    endfunction

    function automatic logic [17:0] mrg(logic [17:0] old, logic [17:0] nw, logic [1:0] m);
        logic [17:0] r;
        r = old;
        if (m[0]) r[8:0]  = nw[8:0];
        if (m[1]) r[17:9] = nw[17:9];
        return r;
    endfunction

    // Drive one cycle of inputs (masks active high here), let one edge pass, settle
    task automatic cyc(input logic rs, input int ra, input logic ws, input int wa,
                       input logic [17:0] dl, input logic [17:0] dh,
                       input logic [1:0] ml, input logic [1:0] mh);
        rd_sel_n     = rs;
        rd_addr      = AW'(ra);
        wr_sel_n     = ws;
        wr_addr      = AW'(wa);
        wr_d_lo      = dl;
        wr_d_hi      = dh;
        wr_bsel_n_lo = ~ml;
        wr_bsel_n_hi = ~mh;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        cyc(1'b1, 0, 1'b1, 0, '0, '0, 2'b00, 2'b00);
    endtask

    task automatic chk(input string tag, input logic eo, input logic [17:0] el, input logic [17:0] eh);
        bit ok;
        n_checks++;
        if (eo) ok = rd_oe && rd_vld_lo && rd_vld_hi && rd_q_lo == el && rd_q_hi == eh;
        else    ok = !rd_oe && !rd_vld_lo && !rd_vld_hi && rd_q_lo == '0 && rd_q_hi == '0;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual oe=%0b vld=%0b%0b lo=%h hi=%h expected oe=%0b lo=%h hi=%h",
                     tag, rd_oe, rd_vld_lo, rd_vld_hi, rd_q_lo, rd_q_hi, eo,
                     eo ? el : 18'h0, eo ? eh : 18'h0);
        end
    endtask

    task automatic apply(input int loc, input int gen, input logic [1:0] m0, input logic [1:0] m1,
                         input logic [1:0] m2, input logic [1:0] m3);
        mdl[loc*4+0] = mrg(mdl[loc*4+0], pat(gen, loc, 0), m0);
        mdl[loc*4+1] = mrg(mdl[loc*4+1], pat(gen, loc, 1), m1);
        mdl[loc*4+2] = mrg(mdl[loc*4+2], pat(gen, loc, 2), m2);
        mdl[loc*4+3] = mrg(mdl[loc*4+3], pat(gen, loc, 3), m3);
    endtask

    task automatic wr_plain(input int loc, input int gen, input logic [1:0] m0, input logic [1:0] m1,
                            input logic [1:0] m2, input logic [1:0] m3);
        cyc(1'b1, 0, 1'b0, loc, '0, '0, 2'b00, 2'b00);
        cyc(1'b1, 0, 1'b1, 0, pat(gen, loc, 0), pat(gen, loc, 1), m0, m1);
        cyc(1'b1, 0, 1'b1, 0, pat(gen, loc, 2), pat(gen, loc, 3), m2, m3);
        apply(loc, gen, m0, m1, m2, m3);
    endtask

    // R3 timing: nothing after the request edge, pairs after the next two, released after that
    task automatic rd_check(input int loc, input string tag);
        cyc(1'b0, loc, 1'b1, 0, '0, '0, 2'b00, 2'b00);
        chk({tag, "/R3 request edge"}, 1'b0, '0, '0);
        idle();
        chk({tag, " words 0/1"}, 1'b1, mdl[loc*4+0], mdl[loc*4+1]);
        idle();
        chk({tag, " words 2/3"}, 1'b1, mdl[loc*4+2], mdl[loc*4+3]);
        idle();
        chk({tag, "/R6 release"}, 1'b0, '0, '0);
    endtask

    initial begin
        #(4 * 50000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [17:0] old0, old1, old2, old3;

        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        chk("R1 in reset", 1'b0, '0, '0);
        rst = 1'b0;
        idle();
        chk("R1 after reset", 1'b0, '0, '0);

        // Fill every location with writes on every other edge (R8 full masks)
        cyc(1'b1, 0, 1'b0, 0, '0, '0, 2'b00, 2'b00);
        for (int loc = 0; loc < LOCS; loc++) begin
            cyc(1'b1, 0, 1'b1, 0, pat(0, loc, 0), pat(0, loc, 1), 2'b11, 2'b11);
            cyc(1'b1, 0, (loc < LOCS - 1) ? 1'b0 : 1'b1, loc + 1,
                pat(0, loc, 2), pat(0, loc, 3), 2'b11, 2'b11);
            apply(loc, 0, 2'b11, 2'b11, 2'b11, 2'b11);
        end

        // R2: single reads of every location
        for (int loc = 0; loc < LOCS; loc++) rd_check(loc, "R2");

        // R5: reads on every other edge stream without gaps
        cyc(1'b0, 0, 1'b1, 0, '0, '0, 2'b00, 2'b00);
        chk("R5 first request", 1'b0, '0, '0);
        for (int i = 0; i < LOCS; i++) begin
            idle();
            chk("R5 stream pair 0/1", 1'b1, mdl[i*4+0], mdl[i*4+1]);
            cyc((i < LOCS - 1) ? 1'b0 : 1'b1, i + 1, 1'b1, 0, '0, '0, 2'b00, 2'b00);
            chk("R5 stream pair 2/3", 1'b1, mdl[i*4+2], mdl[i*4+3]);
        end
        idle();
        chk("R6 release after stream", 1'b0, '0, '0);

        // R4: request on the edge after an accepted read is dropped
        cyc(1'b0, 2, 1'b1, 0, '0, '0, 2'b00, 2'b00);
        chk("R4 request edge", 1'b0, '0, '0);
        cyc(1'b0, 5, 1'b1, 0, '0, '0, 2'b00, 2'b00);
        chk("R4 words 0/1", 1'b1, mdl[8], mdl[9]);
        idle();
        chk("R4 words 2/3", 1'b1, mdl[10], mdl[11]);
        idle();
        chk("R4 dropped request made no burst", 1'b0, '0, '0);

        // R8: partial byte writes, all mask values on each beat position
        for (int loc = 0; loc < LOCS; loc++) begin
            wr_plain(loc, 3, 2'(loc), 2'(loc + 1), 2'(loc + 2), 2'(loc + 3));
            rd_check(loc, "R8");
        end

        // R7: read on the edge after a write to the same location
        for (int loc = 0; loc < LOCS; loc++) begin
            cyc(1'b1, 0, 1'b0, loc, '0, '0, 2'b00, 2'b00);
            chk("R7 write request", 1'b0, '0, '0);
            cyc(1'b0, loc, 1'b1, 0, pat(4, loc, 0), pat(4, loc, 1), 2'(loc), 2'(3 - loc));
            chk("R7 read request", 1'b0, '0, '0);
            cyc(1'b1, 0, 1'b1, 0, pat(4, loc, 2), pat(4, loc, 3), 2'(loc + 1), 2'b11);
            apply(loc, 4, 2'(loc), 2'(3 - loc), 2'(loc + 1), 2'b11);
            chk("R7 forwarded words 0/1", 1'b1, mdl[loc*4+0], mdl[loc*4+1]);
            idle();
            chk("R7 words 2/3", 1'b1, mdl[loc*4+2], mdl[loc*4+3]);
            idle();
            chk("R7 release", 1'b0, '0, '0);
        end

        // R9: read and write of the same location on the same edge
        for (int k = 0; k < 2; k++) begin
            int loc;
            loc = (k == 0) ? 1 : 4;
            old0 = mdl[loc*4+0]; old1 = mdl[loc*4+1];
            old2 = mdl[loc*4+2]; old3 = mdl[loc*4+3];
            cyc(1'b0, loc, 1'b0, loc, '0, '0, 2'b00, 2'b00);
            chk("R9 request edge", 1'b0, '0, '0);
            cyc(1'b1, 0, 1'b1, 0, pat(5, loc, 0), pat(5, loc, 1), 2'b11, 2'b11);
            chk("R9 old words 0/1", 1'b1, old0, old1);
            cyc(1'b1, 0, 1'b1, 0, pat(5, loc, 2), pat(5, loc, 3), 2'b11, 2'b11);
            chk("R9 old words 2/3", 1'b1, old2, old3);
            apply(loc, 5, 2'b11, 2'b11, 2'b11, 2'b11);
            idle();
            chk("R9 release", 1'b0, '0, '0);
            rd_check(loc, "R9 new contents");
        end

        // R10: write request on the edge after an accepted write is dropped
        cyc(1'b1, 0, 1'b0, 1, '0, '0, 2'b00, 2'b00);
        cyc(1'b1, 0, 1'b0, 6, pat(6, 1, 0), pat(6, 1, 1), 2'b11, 2'b11);
        cyc(1'b1, 0, 1'b1, 0, pat(6, 1, 2), pat(6, 1, 3), 2'b11, 2'b11);
        apply(1, 6, 2'b11, 2'b11, 2'b11, 2'b11);
        rd_check(6, "R10 untouched location");
        rd_check(1, "R10 accepted location");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule